// File: doc/BRIEF.md
# Host command stream parser

This block sits at the head of a command processing path. It accepts 32-bit command words over a valid/ready interface and interprets each word as a header or as a payload word. It works out from each header how many payload words follow. Register-style commands become a stream of write transactions, each carrying the current class, a 12-bit register offset and a 32-bit data word. Control commands do not write registers. Restart, gather, lock acquire, lock release and unrecognised extended commands are reported on a separate event port with their decoded fields.

The parser holds the current class from one command to the next, so later writes carry the class set by the most recent class-change command. It does not fetch memory for restart or gather, it does not arbitrate locks, and it does not implement the register targets.

The payload length depends on the opcode. Depending on the command it is a count field, the number of set bits in a mask, or exactly one address word.

Top module: `cmd_stream_parser`

## Requirements
- R1: After reset the parser expects a header, the current class is 0, `inReady` is high and neither output is valid.
- R2: Opcode 1 (bits 31:28) with a nonzero count N in bits 15:0 consumes N payload words. Payload word k is written to offset (bits 27:16) + k.
- R3: Opcode 2 with a nonzero count N consumes N payload words and writes every one of them to the offset in bits 27:16.
- R4: Opcode 3 consumes one payload word per set bit of the 16-bit mask in bits 15:0. Successive words go to offset + i for each set bit i, lowest bit first.
- R5: Opcode 0 loads the class from bits 15:6. With a zero mask in bits 5:0 it produces no write and takes no payload. With a nonzero mask it behaves like R4 over those 6 bits, and the writes carry the new class.
- R6: Opcode 4 produces one write to the offset in bits 27:16, with data equal to bits 15:0 zero-extended. It takes no payload, so the next word is a header.
- R7: Opcode 5 raises an event of kind 0 whose address is the header shifted left by 4 within 32 bits. It takes no payload.
- R8: Opcode 6 consumes exactly one following word. It then raises an event of kind 1 carrying the offset (bits 27:16), the insert flag (bit 15), the type flag (bit 14), the count (bits 13:0), and the following word as the address.
- R9: Opcode 14 raises an event chosen by the sub-op in bits 27:24. Sub-op 0 gives kind 2 and sub-op 1 gives kind 3, each with the lock index from bits 7:0 as the address. Any other sub-op gives kind 4 with the raw header as the address.
- R10: Opcodes 7 to 13 and 15 produce no output and take no payload. The next word is decoded as a header.
- R11: Opcode 1 or 2 with a zero count takes no payload.
- R12: While a write or an event is valid and not accepted, `inReady` is low and the pending output stays stable. No payload word is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inData | input | 32 | Command word |
| inValid | input | 1 | Command word is valid |
| inReady | output | 1 | Parser accepts a word this cycle |
| wrValid | output | 1 | Write transaction is valid |
| wrReady | input | 1 | Write consumer accepts |
| wrClass | output | 10 | Class of the write |
| wrOffset | output | 12 | Register offset of the write |
| wrData | output | 32 | Write data |
| evValid | output | 1 | Event is valid |
| evReady | input | 1 | Event consumer accepts |
| evKind | output | 3 | Event kind: 0 restart, 1 gather, 2 acquire, 3 release, 4 unknown |
| evOffset | output | 12 | Gather offset (0 for other kinds) |
| evInsert | output | 1 | Gather insert flag |
| evType | output | 1 | Gather type flag |
| evCount | output | 14 | Gather count |
| evAddr | output | 32 | Restart target, gather address, lock index or raw header |

## Verification
The hardest case to reach from the ports is a stall that lands in the middle of a payload run. The first payload word must be held on the write port while the next word waits at the input, and the parser must still resume at the correct offset. The stimulus reaches this case by dropping `wrReady` before a two-word incrementing write, so that the first payload word fills the output slot. The second word is then presented for several cycles before the consumer is released. A class-change command with a sparse 6-bit mask, a zero-count write followed by an immediate, and an undefined opcode followed by a restart each show whether the parser has kept its alignment between header and payload words.

// File: rtl/cmdp_pkg.sv
package cmdp_pkg;
  localparam int WORD_W  = 32;
  localparam int CLASS_W = 10;
  localparam int OFF_W   = 12;
  localparam int CNT_W   = 16;
  localparam int GCNT_W  = 14;
  localparam int KIND_W  = 3;

  localparam logic [3:0] OP_SETCL   = 4'd0;
  localparam logic [3:0] OP_INCR    = 4'd1;
  localparam logic [3:0] OP_FIXED   = 4'd2;
  localparam logic [3:0] OP_MASK    = 4'd3;
  localparam logic [3:0] OP_IMM     = 4'd4;
  localparam logic [3:0] OP_RESTART = 4'd5;
  localparam logic [3:0] OP_GATHER  = 4'd6;
  localparam logic [3:0] OP_EXT     = 4'd14;

  typedef enum logic [1:0] {M_INCR, M_FIXED, M_MASK, M_GATHER} paymode_e;
  typedef enum logic [KIND_W-1:0] {
    EV_RESTART = 3'd0, EV_GATHER = 3'd1, EV_ACQ = 3'd2, EV_REL = 3'd3, EV_UNK = 3'd4
  } evkind_e;

  typedef struct packed {
    logic     hdrLoad;
    logic     setClass;
    logic     immWr;
    logic     payWr;
    logic     evFire;
    evkind_e  evKind;
    paymode_e mode;
  } strobe_t;

  function automatic logic [3:0] lowIdx(input logic [CNT_W-1:0] m);
    logic [3:0] idx;
    idx = '0;
    for (int i = CNT_W - 1; i >= 0; i--) if (m[i]) idx = 4'(i);
    return idx;
  endfunction
endpackage

// File: rtl/cmdp_ctrl.sv
module cmdp_ctrl
  import cmdp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] word,
  input  logic              inValid,
  input  logic              outFree,
  input  logic              cntOne,
  input  logic              maskOne,
  output logic              inReady,
  output strobe_t           stb
);
  logic     inPay, nextPay;
  paymode_e mode, nextMode;
  logic     acc, last;

  assign inReady = outFree;
  assign acc = inValid && outFree;

  always_comb begin
    stb = '0;
    stb.mode = mode;
    nextPay = inPay;
    nextMode = mode;
    last = 1'b0;
    if (acc) begin
      if (!inPay) begin
        case (word[31:28])
          OP_SETCL: begin
            stb.setClass = 1'b1;
            if (word[5:0] != '0) begin
              stb.hdrLoad = 1'b1; nextPay = 1'b1; nextMode = M_MASK;
            end
          end
          OP_INCR: if (word[15:0] != '0) begin
            stb.hdrLoad = 1'b1; nextPay = 1'b1; nextMode = M_INCR;
          end
          OP_FIXED: if (word[15:0] != '0) begin
            stb.hdrLoad = 1'b1; nextPay = 1'b1; nextMode = M_FIXED;
          end
          OP_MASK: if (word[15:0] != '0) begin
            stb.hdrLoad = 1'b1; nextPay = 1'b1; nextMode = M_MASK;
          end
          OP_IMM: stb.immWr = 1'b1;
          OP_RESTART: begin
            stb.evFire = 1'b1; stb.evKind = EV_RESTART;
          end
          OP_GATHER: begin
            stb.hdrLoad = 1'b1; nextPay = 1'b1; nextMode = M_GATHER;
          end
          OP_EXT: begin
            stb.evFire = 1'b1;
            case (word[27:24])
              4'd0:    stb.evKind = EV_ACQ;
              4'd1:    stb.evKind = EV_REL;
              default: stb.evKind = EV_UNK;
            endcase
          end
          default: ;
        endcase
      end else begin
        if (mode == M_GATHER) begin
          stb.evFire = 1'b1; stb.evKind = EV_GATHER; last = 1'b1;
        end else begin
          stb.payWr = 1'b1;
          last = (mode == M_MASK) ? maskOne : cntOne;
        end
        if (last) nextPay = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inPay <= 1'b0;
      mode  <= M_INCR;
    end else begin
      inPay <= nextPay;
      mode  <= nextMode;
    end
  end
endmodule

// File: rtl/cmdp_dpath.sv
module cmdp_dpath
  import cmdp_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [WORD_W-1:0]  word,
  input  strobe_t            stb,
  input  logic               wrReady,
  input  logic               evReady,
  output logic               outFree,
  output logic               cntOne,
  output logic               maskOne,
  output logic               wrValid,
  output logic [CLASS_W-1:0] wrClass,
  output logic [OFF_W-1:0]   wrOffset,
  output logic [WORD_W-1:0]  wrData,
  output logic               evValid,
  output logic [KIND_W-1:0]  evKind,
  output logic [OFF_W-1:0]   evOffset,
  output logic               evInsert,
  output logic               evType,
  output logic [GCNT_W-1:0]  evCount,
  output logic [WORD_W-1:0]  evAddr
);
  logic [CLASS_W-1:0] curClass;
  logic [OFF_W-1:0]   baseOff, step, payOff;
  logic [CNT_W-1:0]   cnt, mask;
  logic               gIns, gTyp;
  logic [GCNT_W-1:0]  gCnt;

  assign outFree = (!wrValid || wrReady) && (!evValid || evReady);
  assign cntOne  = (cnt == CNT_W'(1));
  assign maskOne = ((mask & (mask - CNT_W'(1))) == '0);

  always_comb begin
    case (stb.mode)
      M_INCR:  payOff = baseOff + step;
      M_FIXED: payOff = baseOff;
      default: payOff = baseOff + OFF_W'(lowIdx(mask));
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curClass <= '0; baseOff <= '0; step <= '0; cnt <= '0; mask <= '0;
      gIns <= 1'b0; gTyp <= 1'b0; gCnt <= '0;
    end else begin
      if (stb.setClass) curClass <= word[15:6];
      if (stb.hdrLoad) begin
        baseOff <= word[27:16];
        cnt     <= word[15:0];
        mask    <= stb.setClass ? {10'b0, word[5:0]} : word[15:0];
        step    <= '0;
        gIns    <= word[15];
        gTyp    <= word[14];
        gCnt    <= word[13:0];
      end else if (stb.payWr) begin
        cnt  <= cnt - CNT_W'(1);
        step <= step + OFF_W'(1);
        mask <= mask & (mask - CNT_W'(1));
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrValid <= 1'b0; wrClass <= '0; wrOffset <= '0; wrData <= '0;
    end else if (stb.immWr || stb.payWr) begin
      wrValid  <= 1'b1;
      wrClass  <= curClass;
      wrOffset <= stb.immWr ? word[27:16] : payOff;
      wrData   <= stb.immWr ? {16'b0, word[15:0]} : word;
    end else if (wrReady) begin
      wrValid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evValid <= 1'b0; evKind <= '0; evOffset <= '0; evInsert <= 1'b0;
      evType <= 1'b0; evCount <= '0; evAddr <= '0;
    end else if (stb.evFire) begin
      evValid  <= 1'b1;
      evKind   <= stb.evKind;
      evOffset <= (stb.evKind == EV_GATHER) ? baseOff : '0;
      evInsert <= (stb.evKind == EV_GATHER) && gIns;
      evType   <= (stb.evKind == EV_GATHER) && gTyp;
      evCount  <= (stb.evKind == EV_GATHER) ? gCnt : '0;
      case (stb.evKind)
        EV_RESTART:    evAddr <= word << 4;
        EV_ACQ, EV_REL: evAddr <= {24'b0, word[7:0]};
        default:       evAddr <= word;
      endcase
    end else if (evReady) begin
      evValid <= 1'b0;
    end
  end
endmodule

// File: rtl/cmd_stream_parser.sv
module cmd_stream_parser
  import cmdp_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [WORD_W-1:0]  inData,
  input  logic               inValid,
  output logic               inReady,
  output logic               wrValid,
  input  logic               wrReady,
  output logic [CLASS_W-1:0] wrClass,
  output logic [OFF_W-1:0]   wrOffset,
  output logic [WORD_W-1:0]  wrData,
  output logic               evValid,
  input  logic               evReady,
  output logic [KIND_W-1:0]  evKind,
  output logic [OFF_W-1:0]   evOffset,
  output logic               evInsert,
  output logic               evType,
  output logic [GCNT_W-1:0]  evCount,
  output logic [WORD_W-1:0]  evAddr
);
  strobe_t stb;
  logic    outFree, cntOne, maskOne;

  cmdp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .word(inData), .inValid(inValid), .outFree(outFree),
    .cntOne(cntOne), .maskOne(maskOne), .inReady(inReady), .stb(stb)
  );

  cmdp_dpath u_dpath (
    .clk(clk), .rstN(rstN), .word(inData), .stb(stb), .wrReady(wrReady),
    .evReady(evReady), .outFree(outFree), .cntOne(cntOne), .maskOne(maskOne),
    .wrValid(wrValid), .wrClass(wrClass), .wrOffset(wrOffset), .wrData(wrData),
    .evValid(evValid), .evKind(evKind), .evOffset(evOffset), .evInsert(evInsert),
    .evType(evType), .evCount(evCount), .evAddr(evAddr)
  );
endmodule

// File: rtl/cmdp_checker.sv
module cmdp_checker (
  input logic        clk,
  input logic        rstN,
  input logic        inReady,
  input logic        wrValid,
  input logic        wrReady,
  input logic [9:0]  wrClass,
  input logic [11:0] wrOffset,
  input logic [31:0] wrData,
  input logic        evValid,
  input logic        evReady,
  input logic [2:0]  evKind,
  input logic [31:0] evAddr
);
  p_reset_idle_r1: assert property (@(posedge clk) !rstN |=> (!wrValid && !evValid));

  p_wr_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> (wrValid && $stable(wrData) && $stable(wrOffset) && $stable(wrClass)));

  p_ev_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && !evReady) |=> (evValid && $stable(evKind) && $stable(evAddr)));

  p_no_take_r12: assert property (@(posedge clk) disable iff (!rstN)
    ((wrValid && !wrReady) || (evValid && !evReady)) |-> !inReady);

  p_restart_align_r7: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && evKind == 3'd0) |-> (evAddr[3:0] == 4'd0));

  p_kind_legal_r9: assert property (@(posedge clk) disable iff (!rstN)
    evValid |-> (evKind <= 3'd4));

  p_lock_index_r9: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && (evKind == 3'd2 || evKind == 3'd3)) |-> (evAddr[31:8] == 24'd0));
endmodule

bind cmd_stream_parser cmdp_checker u_chk (
  .clk(clk), .rstN(rstN), .inReady(inReady), .wrValid(wrValid), .wrReady(wrReady),
  .wrClass(wrClass), .wrOffset(wrOffset), .wrData(wrData), .evValid(evValid),
  .evReady(evReady), .evKind(evKind), .evAddr(evAddr)
);

// File: tb/cmd_stream_parser_bench.sv
`timescale 1ns/1ps
module cmd_stream_parser_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] inData = '0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic        wrValid, wrReady = 1'b1;
  logic [9:0]  wrClass;
  logic [11:0] wrOffset;
  logic [31:0] wrData;
  logic        evValid, evReady = 1'b1;
  logic [2:0]  evKind;
  logic [11:0] evOffset;
  logic        evInsert, evType;
  logic [13:0] evCount;
  logic [31:0] evAddr;

  always #4 clk = ~clk;

  cmd_stream_parser u_cmd_stream_parser (.*);

  localparam int NSTIM = 25;
  localparam int NWR = 12;
  localparam int NEV = 5;
  localparam logic [31:0] STIM [NSTIM] = '{
    32'h00004A80, 32'h11000003, 32'hA0000001, 32'hA0000002, 32'hA0000003,
    32'h20200002, 32'h000000B1, 32'h000000B2, 32'h30408005, 32'h000000C0,
    32'h000000C2, 32'h000000CF, 32'h40FFBEEF, 32'h91234567, 32'h50001234,
    32'h60AB8123, 32'h80001000, 32'hE0000005, 32'hE100007F, 32'hE3000042,
    32'h0010FFE1, 32'h000000D0, 32'h000000D5, 32'h12000000, 32'h40010007};
  localparam logic [53:0] EXPWR [NWR] = '{
    {10'h12A, 12'h100, 32'hA0000001}, {10'h12A, 12'h101, 32'hA0000002},
    {10'h12A, 12'h102, 32'hA0000003}, {10'h12A, 12'h020, 32'h000000B1},
    {10'h12A, 12'h020, 32'h000000B2}, {10'h12A, 12'h040, 32'h000000C0},
    {10'h12A, 12'h042, 32'h000000C2}, {10'h12A, 12'h04F, 32'h000000CF},
    {10'h12A, 12'h0FF, 32'h0000BEEF}, {10'h3FF, 12'h010, 32'h000000D0},
    {10'h3FF, 12'h015, 32'h000000D5}, {10'h3FF, 12'h001, 32'h00000007}};
  localparam logic [62:0] EXPEV [NEV] = '{
    {3'd0, 12'h000, 1'b0, 1'b0, 14'h0000, 32'h00012340},
    {3'd1, 12'h0AB, 1'b1, 1'b0, 14'h0123, 32'h80001000},
    {3'd2, 12'h000, 1'b0, 1'b0, 14'h0000, 32'h00000005},
    {3'd3, 12'h000, 1'b0, 1'b0, 14'h0000, 32'h0000007F},
    {3'd4, 12'h000, 1'b0, 1'b0, 14'h0000, 32'hE3000042}};

  int checks = 0, fails = 0, cyc = 0, nWr = 0, nEv = 0;
  logic [53:0] gotWr [32];
  logic [62:0] gotEv [16];

  always @(negedge clk) if (rstN) begin
    if (wrValid && wrReady && nWr < 32) begin
      gotWr[nWr] = {wrClass, wrOffset, wrData}; nWr++;
    end
    if (evValid && evReady && nEv < 16) begin
      gotEv[nEv] = {evKind, evOffset, evInsert, evType, evCount, evAddr}; nEv++;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected under 20000", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w);
    inData = w; inValid = 1'b1;
    @(negedge clk);
    while (!inReady) @(negedge clk);
    @(posedge clk); #1;
    inValid = 1'b0;
  endtask

  function automatic string wtag(input int i);
    if (i < 3) return "R2";
    else if (i < 5) return "R3";
    else if (i < 8) return "R4";
    else if (i == 8) return "R6";
    else if (i < 11) return "R5";
    else return "R11";
  endfunction

  function automatic string etag(input int i);
    if (i == 0) return "R7";
    else if (i == 1) return "R8";
    else return "R9";
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(inReady == 1'b1, "R1 inReady", 64'(inReady), 64'd1);
    check(wrValid == 1'b0 && evValid == 1'b0, "R1 outputs idle", {wrValid, evValid}, 64'd0);
    @(posedge clk); #1; rstN = 1'b1;
    @(posedge clk); #1;

    // table phase: stream all words, collect outputs, compare
    for (int i = 0; i < NSTIM; i++) send(STIM[i]);
    repeat (4) @(posedge clk); #1;
    check(nWr == NWR, "R10 write count", 64'(nWr), 64'(NWR));
    check(nEv == NEV, "R10 event count", 64'(nEv), 64'(NEV));
    for (int i = 0; i < NWR; i++)
      check(gotWr[i] === EXPWR[i], wtag(i), 64'(gotWr[i]), 64'(EXPWR[i]));
    for (int i = 0; i < NEV; i++)
      check(gotEv[i] === EXPEV[i], etag(i), 64'(gotEv[i]), 64'(EXPEV[i]));

    // R1: mid-run reset clears the class
    rstN = 1'b0;
    @(negedge clk);
    check(inReady && !wrValid && !evValid, "R1 after reset", {inReady, wrValid, evValid}, 64'h4);
    @(posedge clk); #1; rstN = 1'b1; nWr = 0; nEv = 0;
    @(posedge clk); #1;
    send(32'h40050033);
    repeat (2) @(posedge clk); #1;
    check(nWr == 1 && gotWr[0] === {10'h000, 12'h005, 32'h00000033}, "R1 class zero",
          64'(gotWr[0]), 64'({10'h000, 12'h005, 32'h00000033}));

    // R12: stall inside a payload run
    nWr = 0;
    wrReady = 1'b0;
    send(32'h13000002);
    send(32'h000000F1);
    inData = 32'h000000F2; inValid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(!inReady, "R12 ready low in stall", 64'(inReady), 64'd0);
      check(wrValid && wrData == 32'hF1 && wrOffset == 12'h300, "R12 held write",
            {wrValid, wrOffset, wrData}, {1'b1, 12'h300, 32'hF1});
    end
    @(posedge clk); #1; wrReady = 1'b1;
    @(negedge clk);
    while (!inReady) @(negedge clk);
    @(posedge clk); #1; inValid = 1'b0;
    repeat (3) @(posedge clk); #1;
    check(nWr == 2, "R12 no drop count", 64'(nWr), 64'd2);
    check(gotWr[1] === {10'h000, 12'h301, 32'h000000F2}, "R12 second word",
          64'(gotWr[1]), 64'({10'h000, 12'h301, 32'h000000F2}));

    summary();
    $finish;
  end
endmodule